// File: doc/BRIEF.md
# Serial 4b/5b Line Encoder with NRZI Output

This block converts a stream of tagged nibbles into a self-clocking serial line signal. Each nibble is either one of sixteen data values or, when its escape flag is set, the single escape code. Every nibble is mapped to a 5-bit symbol. The symbol is shifted out one bit per bit-clock enable, most significant bit first. The bit stream then passes through an NRZI stage, which changes the line level on every 1 bit and leaves it unchanged on every 0 bit.

The upstream source presents a nibble together with a valid flag. The block takes a nibble only in the bit slot that carries the final bit of the current symbol. In that slot it raises a ready output for the duration of the enable pulse. If no nibble is offered at that moment, the block sends a filler data symbol. The line therefore keeps toggling and never goes quiet.

Top module: `sym45_nrzi_tx`

## Requirements
- R1: A data nibble d with escape flag 0 and a value outside {0, 4, 8, 12} is sent as the 5-bit symbol {d[3], 1, d[2], d[1], d[0]}. For example, 1 is sent as 01001 and 14 as 11110.
- R2: The four exception data nibbles are sent as follows: 0 as 10101, 4 as 00111, 8 as 10010 and 12 as 10111.
- R3: A nibble offered with the escape flag set is sent as 00010, whatever its data bits are.
- R4: Each symbol is sent most significant bit first, one bit per cycle in which bit_en is high. While bit_en is low, line_out does not change.
- R5: On each enabled bit, line_out toggles when the coded bit is 1 and holds its level when the coded bit is 0.
- R6: nib_ready is high only in a cycle where bit_en is high and the current symbol is on its fifth (last) bit. A nibble offered with nib_valid high in that cycle is taken, and its symbol starts on the next enabled bit. A nibble offered in any other cycle is not taken.
- R7: If nib_valid is low in the ready slot, the next symbol sent is the filler symbol 10101, which is the code for data nibble 0 under the default FILL_NIB.
- R8: After reset, line_out is 0 and the first symbol sent is the filler symbol. The ready slot is the fifth enabled bit.
- R9: The coded bit stream never contains more than 5 consecutive 0 bits, so the line level never stays fixed for more than 5 bit periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable marking a line bit period |
| nib_valid | input | 1 | A nibble is offered |
| nib_data | input | 4 | Nibble value |
| nib_esc | input | 1 | Offered nibble is the escape code |
| nib_ready | output | 1 | Nibble is taken in this cycle if valid |
| line_out | output | 1 | NRZI-coded line bit |

## Verification
The assertions assume that nib_data and nib_esc are meaningful only while nib_valid is high. They also assume that the source treats a transfer as done only in the cycle where both nib_valid and nib_ready are high. The stimulus changes its inputs only between clock edges and keeps nib_valid asserted until a nibble is taken. Bit-enable gaps and long idle runs are inserted so that the hold rule, the filler path and the run-length bound are all exercised. The escape flag is also driven together with nonzero data bits, to confirm that those data bits have no effect on the escape symbol.

// File: rtl/sym45_nrzi_tx.sv
module sym45_nrzi_tx #(
  parameter logic [3:0] FILL_NIB = 4'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       nib_valid,
  input  logic [3:0] nib_data,
  input  logic       nib_esc,
  output logic       nib_ready,
  output logic       line_out
);

  localparam int SYM_W = 5;
  localparam int POS_W = $clog2(SYM_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SYM_W - 1);

  function automatic logic [SYM_W-1:0] enc45(input logic [3:0] d, input logic esc);
    logic [SYM_W-1:0] s;
    if (esc) s = 5'b00010;
    else begin
      case (d)
        4'h0:    s = 5'b10101;
        4'h4:    s = 5'b00111;
        4'h8:    s = 5'b10010;
        4'hC:    s = 5'b10111;
        default: s = {d[3], 1'b1, d[2:0]};
      endcase
    end
    return s;
  endfunction

  localparam logic [SYM_W-1:0] FILL_SYM = enc45(FILL_NIB, 1'b0);

  logic [SYM_W-1:0] sh;
  logic [POS_W-1:0] pos;
  logic             line_q;

  wire last_bit = (pos == LAST_POS);
  wire take     = nib_ready & nib_valid;
  wire [SYM_W-1:0] next_sym = take ? enc45(nib_data, nib_esc) : FILL_SYM;

  assign nib_ready = bit_en & last_bit;
  assign line_out  = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= FILL_SYM;
      pos    <= '0;
      line_q <= 1'b0;
    end else if (bit_en) begin
      line_q <= line_q ^ sh[SYM_W-1];
      if (last_bit) begin
        sh  <= next_sym;
        pos <= '0;
      end else begin
        sh  <= {sh[SYM_W-2:0], 1'b0};
        pos <= POS_W'(pos + 1'b1);
      end
    end
  end

  logic [3:0] zrun;
  always_ff @(posedge clk) begin
    if (!rst_n) zrun <= '0;
    else if (bit_en) zrun <= sh[SYM_W-1] ? 4'd0 : 4'(zrun + 1'b1);
  end

  // R4
  hold_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_out));

  // R5
  toggle_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sh[SYM_W-1]) |=> (line_out != $past(line_out)));

  // R6
  ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_ready |=> (pos == '0));

  // R3
  esc_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_ready && nib_valid && nib_esc) |=> (sh == 5'b00010));

  // R7
  filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_ready && !nib_valid) |=> (sh == FILL_SYM));

  // R9
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= 4'd5);

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST_POS);

endmodule

// File: tb/sym45_nrzi_tx_tb.sv
module sym45_nrzi_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic nib_valid = 1'b0;
  logic nib_esc = 1'b0;
  logic [3:0] nib_data = 4'h0;
  wire  nib_ready;
  wire  line_out;

  always #2 clk = ~clk;

  sym45_nrzi_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nib_valid(nib_valid),
    .nib_data(nib_data), .nib_esc(nib_esc), .nib_ready(nib_ready), .line_out(line_out)
  );

  // {esc, nibble, expected symbol}
  localparam logic [9:0] VEC [0:17] = '{
    {1'b0, 4'h0, 5'b10101}, {1'b0, 4'h1, 5'b01001}, {1'b0, 4'h2, 5'b01010},
    {1'b0, 4'h3, 5'b01011}, {1'b0, 4'h4, 5'b00111}, {1'b0, 4'h5, 5'b01101},
    {1'b0, 4'h6, 5'b01110}, {1'b0, 4'h7, 5'b01111}, {1'b0, 4'h8, 5'b10010},
    {1'b0, 4'h9, 5'b11001}, {1'b0, 4'hA, 5'b11010}, {1'b0, 4'hB, 5'b11011},
    {1'b0, 4'hC, 5'b10111}, {1'b0, 4'hD, 5'b11101}, {1'b0, 4'hE, 5'b11110},
    {1'b0, 4'hF, 5'b11111}, {1'b1, 4'h0, 5'b00010}, {1'b1, 4'h9, 5'b00010}
  };

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] m_sym = 5'b10101;
  int m_idx = 0;
  logic m_line = 1'b0;
  logic obs_prev = 1'b0;
  int zrun = 0;
  int cyc = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [4:0] sym_of(input logic e, input logic [3:0] d);
    if (e) return VEC[16][4:0];
    return VEC[d][4:0];
  endfunction

  task automatic tick(input logic en, input logic v, input logic [3:0] d,
                      input logic e, input string req, output logic acc);
    logic b;
    @(negedge clk);
    bit_en = en; nib_valid = v; nib_data = d; nib_esc = e;
    #1;
    check("R6 ready", int'(nib_ready), int'(en && m_idx == 4));
    acc = en && v && (m_idx == 4);
    @(posedge clk);
    b = 1'b0;
    if (en) begin
      b = m_sym[4 - m_idx];
      m_line = m_line ^ b;
      if (m_idx == 4) begin
        m_sym = acc ? sym_of(e, d) : 5'b10101;
        m_idx = 0;
      end else m_idx++;
    end
    #1;
    if (en) begin
      check({req, " R5 line"}, int'(line_out), int'(m_line));
      check({req, " R4 bit"}, int'(line_out ^ obs_prev), int'(b));
      zrun = (line_out ^ obs_prev) ? 0 : zrun + 1;
      check("R9 run<=5", int'(zrun <= 5), 1);
    end else begin
      check("R4 hold", int'(line_out), int'(obs_prev));
    end
    obs_prev = line_out;
  endtask

  task automatic send(input logic e, input logic [3:0] d, input string req);
    logic acc;
    acc = 1'b0;
    while (!acc) tick(1'b1, 1'b1, d, e, req, acc);
  endtask

  task automatic idle(input int n, input string req);
    logic acc;
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 4'h0, 1'b0, req, acc);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; nib_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 reset line", int'(line_out), 0);
    check("R8 reset ready", int'(nib_ready), 0);
    m_sym = 5'b10101; m_idx = 0; m_line = 1'b0; obs_prev = 1'b0; zrun = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      finish_up();
    end
  end

  initial begin
    logic acc;
    do_reset();
    // R8: first symbol is filler, ready on fifth enabled bit
    idle(5, "R8 first filler");
    // R1 R2 R3: table walk
    for (int k = 0; k < 18; k++) begin
      send(VEC[k][9], VEC[k][8:5], VEC[k][9] ? "R3" : (VEC[k][6:5] == 2'b00 ? "R2" : "R1"));
    end
    idle(5, "R7 after walk");
    // R4: gaps of bit_en mid-symbol with valid held
    tick(1'b1, 1'b1, 4'h6, 1'b0, "R6 offer", acc);
    tick(1'b0, 1'b1, 4'h6, 1'b0, "R4 gap", acc);
    tick(1'b0, 1'b1, 4'h6, 1'b0, "R4 gap", acc);
    send(1'b0, 4'h6, "R6 held");
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b1, 4'hB, 1'b0, "R6 no en", acc);
      tick(1'b1, 1'b0, 4'hB, 1'b0, "R6 drop", acc);
    end
    // R7: long idle, filler only
    idle(30, "R7 idle");
    // R9: zero-heavy sequences
    for (int r = 0; r < 4; r++) begin
      send(1'b1, 4'h0, "R9 esc");
      send(1'b0, 4'h4, "R9 four");
      send(1'b0, 4'h8, "R9 eight");
      send(1'b1, 4'h3, "R9 esc");
    end
    idle(5, "R7");
    // R8: reset mid-symbol
    tick(1'b1, 1'b1, 4'hF, 1'b0, "R8 pre", acc);
    tick(1'b1, 1'b1, 4'hF, 1'b0, "R8 pre", acc);
    do_reset();
    idle(10, "R8 after reset");
    send(1'b0, 4'hD, "R1 after reset");
    idle(5, "R7 tail");
    finish_up();
  end
endmodule